// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

This block turns the sixteen load or store addresses of one half-warp into the short list of memory transactions that serves them. A request carries one address per thread, a mask of the threads that take part, and a code for the access width. The block keeps a set of threads that still need service. On each pass it takes the lowest-numbered thread in that set and finds the aligned segment that holds its address. The segment size depends on the access width. Every pending thread whose address falls in the same segment joins the transaction. The transaction is then narrowed to an aligned half, or to a quarter, when the bytes used leave the rest of the segment untouched.

Each transaction is offered on a valid/ready output with its base address, its byte count and its thread mask. Once accepted, its threads leave the pending set. When the set is empty, a one-cycle completion pulse ends the request, and the block then takes a new one.

Top module: `coalescer`

## Requirements
- R1: The segment size is 32 bytes for size code 0 (1-byte words), 64 bytes for code 1 (2-byte words), and 128 bytes for codes 2, 3 and 4 (4-, 8- and 16-byte words). A transaction is never larger than its segment.
- R2: Each transaction includes the lowest-numbered thread that is still pending, and its segment is the one holding that thread's address.
- R3: A transaction's thread mask (bit i = thread i) holds every pending thread whose address lies in the chosen segment, and no other thread.
- R4: A 128-byte segment whose used bytes lie only in its lower 64 bytes, or only in its upper 64 bytes, is issued as a 64-byte transaction on that half.
- R5: A 64-byte transaction, whether original or reduced from 128, whose used bytes lie in only one 32-byte half of it is issued as 32 bytes on that half.
- R6: The transaction base address is the segment base plus the offset of the chosen half or quarter, so it is aligned to the transaction's byte count.
- R7: Accepted threads leave the pending set, and passes repeat until it is empty. Each active thread is served by exactly one transaction.
- R8: While a transaction is valid and not accepted, it stays valid and its base, byte count and mask do not change.
- R9: The completion pulse is high for one cycle, in the cycle after the last transaction is accepted, and never together with a valid transaction. An empty active mask gives the pulse with no transactions.
- R10: A request is accepted only while the block is idle. The request-ready output is low from the cycle after acceptance until after the completion pulse, and a request held valid meanwhile is not taken.
- R11: A thread uses the bytes from its address through its address plus the word size minus one, clipped at the segment end. A span that reaches into a second half prevents the reduction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle; request taken when both are high |
| reqAddr | input | 512 | Thread addresses, thread i in bits [32i+31:32i] |
| reqMask | input | 16 | Active threads |
| reqSizeCode | input | 3 | Word size code: 0..4 for 1, 2, 4, 8, 16 bytes |
| txnValid | output | 1 | Transaction offered |
| txnReady | input | 1 | Transaction accepted when both are high |
| txnBase | output | 32 | Transaction base address |
| txnBytes | output | 8 | Transaction size: 32, 64 or 128 |
| txnMask | output | 16 | Threads served by the transaction |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can meet in one cycle: the acceptance of the final transaction and a new request that has been waiting on the input. The bench holds the request valid through a whole multi-transaction sequence. At every cycle it checks that request-ready stays low while the block is busy. It then checks that the held request is taken only after the completion pulse, and that it yields the same transaction count again. Stalling the output for several cycles shows separately that an unaccepted transaction holds steady.

// File: rtl/coalPkg.sv
package coalPkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;    // capture a new request
    logic retire;  // drop the threads of the accepted transaction
  } ctlStrobeT;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } coalStateT;

  localparam int unsigned MAX_SEG_BYTES = 128;

endpackage

// File: rtl/coalDatapath.sv
module coalDatapath
  import coalPkg::*;
#(
  parameter int unsigned NUM_THREADS = 16,
  parameter int unsigned ADDR_W      = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobeT                     strobe,
  input  logic [NUM_THREADS*ADDR_W-1:0] reqAddr,
  input  logic [NUM_THREADS-1:0]        reqMask,
  input  logic [2:0]                    reqSizeCode,
  output logic                          pendingEmpty,
  output logic [ADDR_W-1:0]             txnBase,
  output logic [7:0]                    txnBytes,
  output logic [NUM_THREADS-1:0]        txnMask
);

  localparam int unsigned TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;

  logic [ADDR_W-1:0]      addrQ [NUM_THREADS];
  logic [NUM_THREADS-1:0] pendQ;
  logic [2:0]             codeQ;

  // Request storage and pending-set update.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      codeQ <= '0;
    end else if (strobe.load) begin
      pendQ <= reqMask;
      codeQ <= reqSizeCode;
    end else if (strobe.retire) begin
      pendQ <= pendQ & ~txnMask;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      for (int i = 0; i < NUM_THREADS; i++) begin
        addrQ[i] <= reqAddr[i*ADDR_W +: ADDR_W];
      end
    end
  end

  assign pendingEmpty = (pendQ == '0);

  // Word and segment sizing.
  logic [2:0]        effCode;
  logic [7:0]        wordBytes;
  logic [7:0]        segBytes;
  logic [7:0]        segLim;
  logic [ADDR_W-1:0] alignMask;

  always_comb begin
    effCode   = (codeQ > 3'd4) ? 3'd4 : codeQ;
    wordBytes = 8'd1 << effCode;
    case (effCode)
      3'd0:    segBytes = 8'd32;
      3'd1:    segBytes = 8'd64;
      default: segBytes = 8'(MAX_SEG_BYTES);
    endcase
    segLim    = segBytes - 8'd1;
    alignMask = ~(ADDR_W'(segBytes) - ADDR_W'(1));
  end

  // Leader: lowest-numbered pending thread.
  logic [TID_W-1:0]  leadIdx;
  logic [ADDR_W-1:0] segBase;

  always_comb begin
    leadIdx = '0;
    for (int i = NUM_THREADS - 1; i >= 0; i--) begin
      if (pendQ[i]) leadIdx = TID_W'(i);
    end
    segBase = addrQ[leadIdx] & alignMask;
  end

  // Per-thread membership and touched 32-byte chunks of the segment.
  logic [NUM_THREADS-1:0] memb;
  logic [3:0]             thrChunk [NUM_THREADS];

  for (genvar g = 0; g < NUM_THREADS; g++) begin : gThread
    logic [6:0] loOff;
    logic [7:0] hiRaw;
    logic [7:0] hiOff;
    assign loOff       = addrQ[g][6:0] & segLim[6:0];
    assign hiRaw       = {1'b0, loOff} + wordBytes - 8'd1;
    assign hiOff       = (hiRaw > segLim) ? segLim : hiRaw;
    assign memb[g]     = pendQ[g] && ((addrQ[g] & alignMask) == segBase);
    assign thrChunk[g] = memb[g] ? ((4'b0001 << loOff[6:5]) | (4'b0001 << hiOff[6:5]))
                                 : 4'b0000;
  end

  logic [3:0] touched;
  always_comb begin
    touched = '0;
    for (int i = 0; i < NUM_THREADS; i++) touched |= thrChunk[i];
  end

  // Size reduction: 128 -> 64 -> 32 on the half that is used.
  logic [6:0] offB;
  logic [7:0] sz;
  logic [1:0] q;

  always_comb begin
    offB = '0;
    sz   = segBytes;
    if (sz == 8'd128) begin
      if (touched[3:2] == 2'b00) begin
        sz = 8'd64;
      end else if (touched[1:0] == 2'b00) begin
        sz   = 8'd64;
        offB = 7'd64;
      end
    end
    q = offB[6:5];
    if (sz == 8'd64) begin
      if (!touched[q + 2'd1]) begin
        sz = 8'd32;
      end else if (!touched[q]) begin
        sz   = 8'd32;
        offB = offB + 7'd32;
      end
    end
  end

  assign txnBase  = segBase | ADDR_W'(offB);
  assign txnBytes = sz;
  assign txnMask  = memb;

endmodule

// File: rtl/coalControl.sv
module coalControl
  import coalPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      txnReady,
  input  logic      pendingEmpty,
  output logic      reqReady,
  output logic      txnValid,
  output logic      done,
  output ctlStrobeT strobe
);

  coalStateT stateQ;
  coalStateT stateD;

  always_comb begin
    reqReady      = (stateQ == ST_IDLE);
    txnValid      = (stateQ == ST_BUSY) && !pendingEmpty;
    done          = (stateQ == ST_BUSY) && pendingEmpty;
    strobe.load   = reqReady && reqValid;
    strobe.retire = txnValid && txnReady;
    stateD        = stateQ;
    case (stateQ)
      ST_IDLE: if (strobe.load) stateD = ST_BUSY;
      ST_BUSY: if (pendingEmpty) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/coalescer.sv
module coalescer
  import coalPkg::*;
#(
  parameter int unsigned NUM_THREADS = 16,
  parameter int unsigned ADDR_W      = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [NUM_THREADS*ADDR_W-1:0] reqAddr,
  input  logic [NUM_THREADS-1:0]        reqMask,
  input  logic [2:0]                    reqSizeCode,
  output logic                          txnValid,
  input  logic                          txnReady,
  output logic [ADDR_W-1:0]             txnBase,
  output logic [7:0]                    txnBytes,
  output logic [NUM_THREADS-1:0]        txnMask,
  output logic                          done
);

  ctlStrobeT strobe;
  logic      pendingEmpty;

  coalControl uCtl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .txnReady     (txnReady),
    .pendingEmpty (pendingEmpty),
    .reqReady     (reqReady),
    .txnValid     (txnValid),
    .done         (done),
    .strobe       (strobe)
  );

  coalDatapath #(
    .NUM_THREADS (NUM_THREADS),
    .ADDR_W      (ADDR_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqAddr      (reqAddr),
    .reqMask      (reqMask),
    .reqSizeCode  (reqSizeCode),
    .pendingEmpty (pendingEmpty),
    .txnBase      (txnBase),
    .txnBytes     (txnBytes),
    .txnMask      (txnMask)
  );

endmodule

// File: rtl/coalChecker.sv
module coalChecker #(
  parameter int unsigned NUM_THREADS = 16,
  parameter int unsigned ADDR_W      = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic                   reqReady,
  input logic [NUM_THREADS-1:0] reqMask,
  input logic                   txnValid,
  input logic                   txnReady,
  input logic [ADDR_W-1:0]      txnBase,
  input logic [7:0]             txnBytes,
  input logic [NUM_THREADS-1:0] txnMask,
  input logic                   done
);

  // Independent record of threads not yet served, built from port traffic.
  logic [NUM_THREADS-1:0] remain;
  always_ff @(posedge clk) begin
    if (!rstN)                      remain <= '0;
    else if (reqValid && reqReady)  remain <= reqMask;
    else if (txnValid && txnReady)  remain <= remain & ~txnMask;
  end

  p_legal_size_r1: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> (txnBytes == 8'd32 || txnBytes == 8'd64 || txnBytes == 8'd128));

  p_leader_in_r2: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> ((txnMask & remain & (~remain + 1'b1)) != '0));

  p_nonempty_r3: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> (txnMask != '0));

  p_base_align_r6: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> ((txnBase & (ADDR_W'(txnBytes) - ADDR_W'(1))) == '0));

  p_subset_r7: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> ((txnMask & ~remain) == '0));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    txnValid && !txnReady |=> txnValid && $stable(txnBase) && $stable(txnBytes)
                              && $stable(txnMask));

  p_done_clean_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !txnValid && (remain == '0));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && reqReady);

  p_busy_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

endmodule

bind coalescer coalChecker #(
  .NUM_THREADS (NUM_THREADS),
  .ADDR_W      (ADDR_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqMask  (reqMask),
  .txnValid (txnValid),
  .txnReady (txnReady),
  .txnBase  (txnBase),
  .txnBytes (txnBytes),
  .txnMask  (txnMask),
  .done     (done)
);

// File: tb/sim_coalescer.sv
module sim_coalescer;

  localparam int NT = 16;
  localparam int AW = 32;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           reqValid = 1'b0;
  logic           reqReady;
  logic [NT*AW-1:0] reqAddr = '0;
  logic [NT-1:0]  reqMask = '0;
  logic [2:0]     reqSizeCode = '0;
  logic           txnValid;
  logic           txnReady = 1'b1;
  logic [AW-1:0]  txnBase;
  logic [7:0]     txnBytes;
  logic [NT-1:0]  txnMask;
  logic           done;

  always #2.5 clk = ~clk;  // 200 MHz

  coalescer #(.NUM_THREADS(NT), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqMask(reqMask), .reqSizeCode(reqSizeCode),
    .txnValid(txnValid), .txnReady(txnReady), .txnBase(txnBase),
    .txnBytes(txnBytes), .txnMask(txnMask), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Collected transactions of the last request.
  logic [AW-1:0] gBase [NT];
  logic [7:0]    gBytes [NT];
  logic [NT-1:0] gMask [NT];
  int            nTx;
  bit            sawDone;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] stride;
    logic [2:0]  code;
    logic [15:0] mask;
    logic [31:0] eBase;
    logic [7:0]  eBytes;
    logic [15:0] eMask;
    logic [4:0]  eCount;
    logic [3:0]  req;
  } vecT;

  // thread i address = base + i*stride; expectations are for the first transaction
  localparam vecT VECS [12] = '{
    '{32'h1000, 32'd4,   3'd2, 16'hFFFF, 32'h1000, 8'd64,  16'hFFFF, 5'd1,  4'd4},  // R4 lower half
    '{32'h1000, 32'd8,   3'd2, 16'hFFFF, 32'h1000, 8'd128, 16'hFFFF, 5'd1,  4'd1},  // R1 full 128
    '{32'h2000, 32'd1,   3'd0, 16'hFFFF, 32'h2000, 8'd32,  16'hFFFF, 5'd1,  4'd1},  // R1 bytes
    '{32'h3000, 32'd4,   3'd1, 16'hFFFF, 32'h3000, 8'd64,  16'hFFFF, 5'd1,  4'd1},  // R1 halfwords
    '{32'h1040, 32'd1,   3'd2, 16'hFFFF, 32'h1040, 8'd32,  16'hFFFF, 5'd1,  4'd5},  // R5 128->64->32
    '{32'h1060, 32'd0,   3'd3, 16'hFFFF, 32'h1060, 8'd32,  16'hFFFF, 5'd1,  4'd6},  // R6 top quarter
    '{32'h4020, 32'd2,   3'd1, 16'hFFFF, 32'h4020, 8'd32,  16'hFFFF, 5'd1,  4'd5},  // R5 from 64
    '{32'h5000, 32'd128, 3'd2, 16'hFFFF, 32'h5000, 8'd32,  16'h0001, 5'd16, 4'd7},  // R7 scattered
    '{32'h1000, 32'd4,   3'd2, 16'hFFF0, 32'h1000, 8'd64,  16'hFFF0, 5'd1,  4'd2},  // R2 leader thread 4
    '{32'h203C, 32'd0,   3'd3, 16'h0001, 32'h2000, 8'd128, 16'h0001, 5'd1,  4'd11}, // R11 straddle
    '{32'h6000, 32'd16,  3'd4, 16'h00FF, 32'h6000, 8'd128, 16'h00FF, 5'd1,  4'd1},  // R1 16-byte words
    '{32'h7000, 32'd64,  3'd2, 16'hFFFF, 32'h7000, 8'd128, 16'h0003, 5'd8,  4'd3}   // R3 pairs
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic setReq(input logic [31:0] base, input logic [31:0] stride,
                        input logic [2:0] code, input logic [15:0] mask);
    for (int i = 0; i < NT; i++) reqAddr[i*AW +: AW] = base + 32'(i) * stride;
    reqMask     = mask;
    reqSizeCode = code;
  endtask

  // Gather transactions until the completion pulse; called at a negedge.
  task automatic collect();
    int guard = 0;
    nTx = 0;
    sawDone = 0;
    while (!sawDone && guard < 200) begin
      if (done) begin
        sawDone = 1;
      end else begin
        if (txnValid && txnReady && nTx < NT) begin
          gBase[nTx]  = txnBase;
          gBytes[nTx] = txnBytes;
          gMask[nTx]  = txnMask;
          nTx++;
        end
        @(negedge clk);
      end
      guard++;
    end
  endtask

  task automatic runReq(input logic [31:0] base, input logic [31:0] stride,
                        input logic [2:0] code, input logic [15:0] mask);
    @(negedge clk);
    setReq(base, stride, code, mask);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    collect();
  endtask

  task automatic coverCheck(input logic [15:0] mask, input string tag);
    logic [15:0] uni = '0;
    bit overlap = 0;
    for (int k = 0; k < nTx; k++) begin
      if ((uni & gMask[k]) != '0) overlap = 1;
      uni |= gMask[k];
    end
    chk(uni == mask && !overlap, tag, 32'(uni), 32'(mask));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(txnValid == 1'b0 && done == 1'b0, "R9 reset outputs", {30'd0, txnValid, done}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R10 idle after reset", 32'(reqReady), 32'd1);

    // table walk
    foreach (VECS[v]) begin
      runReq(VECS[v].base, VECS[v].stride, VECS[v].code, VECS[v].mask);
      chk(sawDone, $sformatf("R%0d done seen vec%0d", VECS[v].req, v), 32'(sawDone), 32'd1);
      chk(nTx == int'(VECS[v].eCount), $sformatf("R%0d count vec%0d", VECS[v].req, v),
          32'(nTx), 32'(VECS[v].eCount));
      if (nTx > 0) begin
        chk(gBase[0] == VECS[v].eBase, $sformatf("R%0d base vec%0d", VECS[v].req, v),
            gBase[0], VECS[v].eBase);
        chk(gBytes[0] == VECS[v].eBytes, $sformatf("R%0d bytes vec%0d", VECS[v].req, v),
            32'(gBytes[0]), 32'(VECS[v].eBytes));
        chk(gMask[0] == VECS[v].eMask, $sformatf("R%0d mask vec%0d", VECS[v].req, v),
            32'(gMask[0]), 32'(VECS[v].eMask));
      end
      coverCheck(VECS[v].mask, $sformatf("R7 coverage vec%0d", v));
    end

    // R3: interleaved segments, even threads at 0x8000+4i, odd at 0x9000+4i
    @(negedge clk);
    for (int i = 0; i < NT; i++)
      reqAddr[i*AW +: AW] = ((i % 2) == 0 ? 32'h8000 : 32'h9000) + 32'(4 * i);
    reqMask = 16'hFFFF;
    reqSizeCode = 3'd2;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    collect();
    chk(nTx == 2, "R3 interleave count", 32'(nTx), 32'd2);
    chk(gMask[0] == 16'h5555 && gBase[0] == 32'h8000 && gBytes[0] == 8'd64,
        "R3 first txn", gBase[0], 32'h8000);
    chk(gMask[1] == 16'hAAAA && gBase[1] == 32'h9000 && gBytes[1] == 8'd64,
        "R3 second txn", gBase[1], 32'h9000);

    // R9: empty mask gives completion with no transactions
    runReq(32'h0, 32'd4, 3'd2, 16'h0000);
    chk(sawDone && nTx == 0, "R9 empty mask", 32'(nTx), 32'd0);

    // R8: stall the output for three cycles
    @(negedge clk);
    txnReady = 1'b0;
    setReq(32'h5000, 32'd128, 3'd2, 16'h0003);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    begin
      logic [31:0] holdBase;
      holdBase = txnBase;
      repeat (3) @(negedge clk);
      chk(txnValid && txnBase == holdBase && txnMask == 16'h0001, "R8 stall hold",
          txnBase, holdBase);
    end
    txnReady = 1'b1;
    collect();
    chk(nTx == 2 && gBase[1] == 32'h5080, "R8 drain after stall", gBase[1], 32'h5080);

    // R10: request held valid across a busy sequence
    @(negedge clk);
    setReq(32'h5000, 32'd128, 3'd2, 16'h0003);
    reqValid = 1'b1;
    @(negedge clk);
    begin
      int busyBad = 0;
      int guard = 0;
      nTx = 0;
      while (!done && guard < 50) begin
        if (reqReady) busyBad++;
        if (txnValid) nTx++;
        @(negedge clk);
        guard++;
      end
      chk(busyBad == 0, "R10 ready low while busy", 32'(busyBad), 32'd0);
      chk(nTx == 2, "R10 first pass count", 32'(nTx), 32'd2);
    end
    @(negedge clk);
    chk(reqReady == 1'b1, "R10 idle after done", 32'(reqReady), 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R10 held request taken", 32'(reqReady), 32'd0);
    collect();
    chk(nTx == 2 && sawDone, "R10 second pass count", 32'(nTx), 32'd2);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule